// File: doc/BRIEF.md
# Clock Synthesizer Configuration Port Bridge

This block is a small register-bank slave. A processor uses it to reach the internal register space of a reconfigurable clock synthesizer. That register space sits behind a narrow request/ready configuration port with a 7-bit address and 16-bit data. Single-beat 32-bit word accesses land on four fixed byte offsets:

- 0x40 holds the reset/enable control.
- 0x44 picks the input clock.
- 0x70 takes a port command.
- 0x74 reports progress and the last read result.

Software issues one port transaction by writing a command word. The bridge latches the port select, direction, address and data from that word and drives them onto the port until the synthesizer answers with ready. While the transaction is open, the status word shows busy. When a read transaction completes, the status word holds the 16-bit value returned by the synthesizer. Software polls busy before it issues the next command, and before it trusts the read data.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, `core_en`, `synth_run`, `clk_sel` and `prt_req` are 0, and every mapped offset reads 0. The synthesizer therefore starts held in reset, with input 0 selected.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `core_en` and bit 1 drives `synth_run`; a 0 in bit 1 holds the synthesizer in reset. A read of 0x40 returns these two bits, with zeros above them.
- R3: A write to offset 0x44 stores the clock select in its low bits (one bit with two inputs), drives `clk_sel`, and reads back with all higher bits zero.
- R4: A write to offset 0x70 while idle with bit 29 set opens a transaction. In the next cycle, `prt_req` is 1, `prt_we` is the inverse of bit 28 (1 means read), `prt_addr` is bits 22:16 and `prt_wdata` is bits 15:0. A read of 0x70 then returns bit 29, bit 28 and these fields of the accepted command.
- R5: While a transaction is open, status offset 0x74 bit 16 (busy) reads 1. In the cycle after an edge at which `prt_rdy` is sampled high with `prt_req`, `prt_req` is 0 and busy reads 0.
- R6: When a read transaction completes, status bits 15:0 take the value on `prt_rdata` at the completing edge. A write transaction leaves those bits unchanged.
- R7: The port fields stay stable until ready. A command write that arrives while busy is ignored: the open transaction, the 0x70 readback and the status word are unchanged, and no second transaction follows.
- R8: A command write with bit 29 clear opens no transaction and leaves the 0x70 readback unchanged.
- R9: Reads of unmapped offsets return 0, and writes to them change no register. Every read returns its data in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-beat write strobe |
| bus_rd | input | 1 | Single-beat read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| core_en | output | 1 | General enable |
| synth_run | output | 1 | Synthesizer out of reset when 1 |
| clk_sel | output | SEL_W | Input clock select |
| prt_req | output | 1 | Port transaction open (busy) |
| prt_we | output | 1 | Transaction is a write |
| prt_addr | output | 7 | Port register address |
| prt_wdata | output | 16 | Port write data |
| prt_rdy | input | 1 | Port completes the transaction |
| prt_rdata | input | 16 | Port read data, valid with prt_rdy |

## Verification
Randomly ordered reads and writes to random port addresses run against a register-file port model with random response latency. A read that returns a value other than the one last written to that address shows a bad field latch or a bad capture. Directed cases do three more things:

- They hold the port's response back, so that busy is observed high and a second command can be pushed at the busy bridge. The readback and a later read of the second command's target address then show whether that command leaked through.
- They issue a command word without the select bit.
- They write and read an unmapped offset, to separate proper decoding from aliasing onto the control registers.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
   localparam int BUS_DW  = 32;
   localparam int PORT_AW = 7;
   localparam int PORT_DW = 16;

   localparam int OFF_CTL  = 'h40;
   localparam int OFF_SEL  = 'h44;
   localparam int OFF_CMD  = 'h70;
   localparam int OFF_STAT = 'h74;

   localparam int CMD_SEL_BIT   = 29;
   localparam int CMD_RD_BIT    = 28;
   localparam int CMD_ADDR_LSB  = 16;
   localparam int STAT_BUSY_BIT = 16;
   localparam int CTL_W         = 2;
endpackage

// File: rtl/cpb_port_seq.sv
module cpb_port_seq
   import cpb_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_stb,
   input  logic [BUS_DW-1:0]  cmd_word,
   input  logic               prt_rdy,
   input  logic [PORT_DW-1:0] prt_rdata,
   output logic               busy,
   output logic               prt_we,
   output logic [PORT_AW-1:0] prt_addr,
   output logic [PORT_DW-1:0] prt_wdata,
   output logic [PORT_DW-1:0] rd_data,
   output logic [BUS_DW-1:0]  cmd_echo
);
   logic accept;
   logic seen;

   assign accept = cmd_stb && !busy && cmd_word[CMD_SEL_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         seen      <= 1'b0;
         prt_we    <= 1'b0;
         prt_addr  <= '0;
         prt_wdata <= '0;
         rd_data   <= '0;
      end else if (accept) begin
         busy      <= 1'b1;
         seen      <= 1'b1;
         prt_we    <= !cmd_word[CMD_RD_BIT];
         prt_addr  <= cmd_word[CMD_ADDR_LSB +: PORT_AW];
         prt_wdata <= cmd_word[PORT_DW-1:0];
      end else if (busy && prt_rdy) begin
         busy <= 1'b0;
         if (!prt_we) rd_data <= prt_rdata;
      end
   end

   always_comb begin
      cmd_echo = '0;
      if (seen) begin
         cmd_echo[CMD_SEL_BIT]                  = 1'b1;
         cmd_echo[CMD_RD_BIT]                   = !prt_we;
         cmd_echo[CMD_ADDR_LSB +: PORT_AW]      = prt_addr;
         cmd_echo[PORT_DW-1:0]                  = prt_wdata;
      end
   end

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{cmd_word[BUS_DW-1:CMD_SEL_BIT+1],
                              cmd_word[CMD_RD_BIT-1:CMD_ADDR_LSB+PORT_AW]};
endmodule

// File: rtl/cpb_regs.sv
module cpb_regs
   import cpb_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_CLK = 2,
   parameter int SEL_W   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_DW-1:0]  bus_wdata,
   input  logic               busy,
   input  logic [PORT_DW-1:0] rd_data,
   input  logic [BUS_DW-1:0]  cmd_echo,
   output logic               cmd_stb,
   output logic [CTL_W-1:0]   ctl_q,
   output logic [SEL_W-1:0]   sel_q,
   output logic [BUS_DW-1:0]  bus_rdata
);
   logic hit_ctl, hit_sel, hit_cmd, hit_stat;

   assign hit_ctl  = bus_addr == ADDR_W'(OFF_CTL);
   assign hit_sel  = bus_addr == ADDR_W'(OFF_SEL);
   assign hit_cmd  = bus_addr == ADDR_W'(OFF_CMD);
   assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
   assign cmd_stb  = bus_wr && hit_cmd;

   always_ff @(posedge clk) begin
      if (!rst_n)                ctl_q <= '0;
      else if (bus_wr && hit_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
   end

   generate
      if (NUM_CLK > 1) begin : g_sel_reg
         always_ff @(posedge clk) begin
            if (!rst_n)                 sel_q <= '0;
            else if (bus_wr && hit_sel) sel_q <= bus_wdata[SEL_W-1:0];
         end
      end else begin : g_sel_fixed
         assign sel_q = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= '0;
         if (hit_ctl)  bus_rdata <= BUS_DW'(ctl_q);
         if (hit_sel)  bus_rdata <= BUS_DW'(sel_q);
         if (hit_cmd)  bus_rdata <= cmd_echo;
         if (hit_stat) bus_rdata <= BUS_DW'({busy, rd_data});
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata[BUS_DW-1:CTL_W];
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cpb_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_CLK = 2,
   localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_DW-1:0]  bus_wdata,
   output logic [BUS_DW-1:0]  bus_rdata,
   output logic               core_en,
   output logic               synth_run,
   output logic [SEL_W-1:0]   clk_sel,
   output logic               prt_req,
   output logic               prt_we,
   output logic [PORT_AW-1:0] prt_addr,
   output logic [PORT_DW-1:0] prt_wdata,
   input  logic               prt_rdy,
   input  logic [PORT_DW-1:0] prt_rdata
);
   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x74");
      end
      if (NUM_CLK < 1 || NUM_CLK > 2) begin : g_bad_clk
         $error("NUM_CLK must be 1 or 2");
      end
   endgenerate

   logic               cmd_stb;
   logic               busy;
   logic [PORT_DW-1:0] rd_data;
   logic [BUS_DW-1:0]  cmd_echo;
   logic [CTL_W-1:0]   ctl_q;

   cpb_regs #(.ADDR_W(ADDR_W), .NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
      .rd_data(rd_data), .cmd_echo(cmd_echo), .cmd_stb(cmd_stb),
      .ctl_q(ctl_q), .sel_q(clk_sel), .bus_rdata(bus_rdata)
   );

   cpb_port_seq u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_word(bus_wdata),
      .prt_rdy(prt_rdy), .prt_rdata(prt_rdata), .busy(busy),
      .prt_we(prt_we), .prt_addr(prt_addr), .prt_wdata(prt_wdata),
      .rd_data(rd_data), .cmd_echo(cmd_echo)
   );

   assign core_en   = ctl_q[0];
   assign synth_run = ctl_q[1];
   assign prt_req   = busy;
endmodule

// File: rtl/cpb_checker.sv
module cpb_checker
   import cpb_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [BUS_DW-1:0]  bus_wdata,
   input logic [BUS_DW-1:0]  bus_rdata,
   input logic               prt_req,
   input logic               prt_we,
   input logic [PORT_AW-1:0] prt_addr,
   input logic [PORT_DW-1:0] prt_wdata,
   input logic               prt_rdy
);
   logic cmd_hit, unmapped;
   assign cmd_hit  = bus_addr == ADDR_W'(OFF_CMD);
   assign unmapped = bus_addr != ADDR_W'(OFF_CTL) && bus_addr != ADDR_W'(OFF_SEL) &&
                     bus_addr != ADDR_W'(OFF_CMD) && bus_addr != ADDR_W'(OFF_STAT);

   assert_open_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prt_req) |-> $past(bus_wr && cmd_hit && bus_wdata[CMD_SEL_BIT]));

   assert_ready_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prt_req && prt_rdy |=> !prt_req);

   assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      prt_req && !prt_rdy |=> prt_req && $stable(prt_addr) && $stable(prt_wdata) && $stable(prt_we));

   assert_no_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !prt_req && bus_wr && cmd_hit && !bus_wdata[CMD_SEL_BIT] |=> !prt_req);

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && unmapped |=> bus_rdata == '0);
endmodule

bind cfg_port_bridge cpb_checker #(.ADDR_W(ADDR_W)) u_cpb_checker (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .prt_req(prt_req), .prt_we(prt_we), .prt_addr(prt_addr),
   .prt_wdata(prt_wdata), .prt_rdy(prt_rdy)
);

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        core_en, synth_run;
   logic [0:0]  clk_sel;
   logic        prt_req, prt_we;
   logic [6:0]  prt_addr;
   logic [15:0] prt_wdata;
   logic        prt_rdy = 1'b0;
   logic [15:0] prt_rdata = '0;

   int n_cmp = 0, n_bad = 0;
   int model_lat = 2;
   int lat_cnt = 0;
   logic [15:0] port_mem [128];
   logic [15:0] ref_mem  [128];
   logic [31:0] rv;

   always #2 clk = ~clk;

   cfg_port_bridge i_cfg_port_bridge (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_en(core_en), .synth_run(synth_run), .clk_sel(clk_sel),
      .prt_req(prt_req), .prt_we(prt_we), .prt_addr(prt_addr),
      .prt_wdata(prt_wdata), .prt_rdy(prt_rdy), .prt_rdata(prt_rdata)
   );

   // register-file model of the synthesizer's configuration port
   always @(negedge clk) begin
      if (prt_rdy) begin
         if (prt_we) port_mem[prt_addr] = prt_wdata;
         prt_rdy = 1'b0;
         lat_cnt = 0;
      end else if (prt_req) begin
         lat_cnt = lat_cnt + 1;
         if (lat_cnt >= model_lat) begin
            prt_rdy   = 1'b1;
            prt_rdata = port_mem[prt_addr];
         end
      end
   end

   function automatic logic [31:0] make_cmd(bit sel, bit rd, logic [6:0] a, logic [15:0] d);
      return (32'(sel) << 29) | (32'(rd) << 28) | (32'(a) << 16) | 32'(d);
   endfunction

   function automatic logic [31:0] exp_status(bit busy, logic [15:0] d);
      return (32'(busy) << 16) | 32'(d);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_idle(output logic [31:0] st);
      for (int i = 0; i < 100; i++) begin
         bus_read(8'h74, st);
         if (!st[16]) return;
      end
      chk("R5 busy never cleared", st, st & ~32'h10000);
   endtask

   task automatic do_write(logic [6:0] a, logic [15:0] d);
      logic [31:0] st;
      bus_write(8'h70, make_cmd(1, 0, a, d));
      ref_mem[a] = d;
      wait_idle(st);
   endtask

   task automatic do_read(logic [6:0] a, string req);
      logic [31:0] st;
      bus_write(8'h70, make_cmd(1, 1, a, 16'h0));
      wait_idle(st);
      chk(req, st, exp_status(0, ref_mem[a]));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 128; i++) begin
         port_mem[i] = '0;
         ref_mem[i]  = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk("R1 outputs", {28'(0), core_en, synth_run, clk_sel, prt_req}, 32'h0);
      bus_read(8'h40, rv); chk("R1 ctl", rv, 0);
      bus_read(8'h44, rv); chk("R1 sel", rv, 0);
      bus_read(8'h70, rv); chk("R1 cmd", rv, 0);
      bus_read(8'h74, rv); chk("R1 stat", rv, 0);

      // R2 control register
      bus_write(8'h40, 32'h3);
      chk("R2 pins", {30'(0), synth_run, core_en}, 32'h3);
      bus_read(8'h40, rv); chk("R2 readback", rv, 32'h3);
      bus_write(8'h40, 32'hFFFF_FFFE);
      chk("R2 pins hold", {30'(0), synth_run, core_en}, 32'h2);
      bus_read(8'h40, rv); chk("R2 readback mask", rv, 32'h2);

      // R3 clock select
      bus_write(8'h44, 32'h1);
      chk("R3 pin", 32'(clk_sel), 32'h1);
      bus_read(8'h44, rv); chk("R3 readback", rv, 32'h1);
      bus_write(8'h44, 32'hFFFF_FFFE);
      bus_read(8'h44, rv); chk("R3 mask", rv, 32'h0);

      // R9 unmapped offsets
      bus_write(8'h48, 32'hFFFF_FFFF);
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_read(8'h48, rv); chk("R9 read 0x48", rv, 0);
      bus_read(8'h7C, rv); chk("R9 read 0x7C", rv, 0);
      bus_read(8'h40, rv); chk("R9 ctl untouched", rv, 32'h2);
      bus_read(8'h44, rv); chk("R9 sel untouched", rv, 32'h0);

      // R4 field latch with slow port
      model_lat = 8;
      bus_write(8'h70, make_cmd(1, 0, 7'h5A, 16'hBEEF));
      ref_mem[7'h5A] = 16'hBEEF;
      chk("R4 port fields", {8'(prt_req), 8'(prt_we), 8'(prt_addr), 8'h0} | 32'(prt_wdata),
          {8'h1, 8'h1, 8'h5A, 8'h0} | 32'hBEEF);
      bus_read(8'h74, rv); chk("R5 busy high", rv, exp_status(1, 0));
      bus_read(8'h70, rv); chk("R4 cmd echo", rv, make_cmd(1, 0, 7'h5A, 16'hBEEF));
      wait_idle(rv);
      chk("R6 write keeps data", rv, exp_status(0, 0));
      chk("R5 req low", 32'(prt_req), 0);

      // R7 command while busy is ignored
      bus_write(8'h70, make_cmd(1, 1, 7'h5A, 16'h0));
      bus_write(8'h70, make_cmd(1, 0, 7'h11, 16'h1234));
      bus_read(8'h70, rv); chk("R7 echo kept", rv, make_cmd(1, 1, 7'h5A, 16'h0));
      wait_idle(rv);
      chk("R7 status from first read", rv, exp_status(0, 16'hBEEF));
      repeat (4) @(negedge clk);
      chk("R7 no second transaction", 32'(prt_req), 0);
      model_lat = 1;
      do_read(7'h11, "R7 ignored write left port memory");

      // R8 no select bit
      bus_write(8'h70, make_cmd(0, 0, 7'h22, 16'h5555));
      repeat (3) @(negedge clk);
      chk("R8 no req", 32'(prt_req), 0);
      bus_read(8'h70, rv); chk("R8 echo unchanged", rv, make_cmd(1, 1, 7'h11, 16'h0));

      // R6 random traffic
      for (int i = 0; i < 60; i++) begin
         logic [6:0]  a;
         logic [15:0] d;
         a = 7'($urandom % 128);
         d = 16'($urandom);
         model_lat = 1 + ($urandom % 4);
         if ($urandom % 2) do_write(a, d);
         else do_read(a, "R6 random read");
      end
      for (int i = 0; i < 8; i++) begin
         model_lat = 1 + ($urandom % 4);
         do_read(7'($urandom % 128), "R6 sweep read");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule